// File: doc/BRIEF.md
# Nested Interrupt Priority Resolver

This block arbitrates among a set of interrupt request lines, eight by default, using a fixed priority order. Each line is captured on its rising edge into a pending register. A pending line can win only when it is not masked and nothing of equal or higher priority is currently being serviced. When a line can win, the block raises an interrupt to the processor and reports the index of the winning line.

An acknowledge pulse moves the winning line from pending to in-service. A non-specific end-of-interrupt command retires the highest-priority in-service level. The in-service register is always visible, so software can check whether it is empty after an end-of-interrupt.

A mode input selects plain nesting or special nesting. Special nesting is meant for a master that has downstream controllers on some of its inputs. In that mode, a line that is already in service may raise the interrupt again, so a more urgent request behind the same downstream controller still gets through.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, the pending, in-service and mask registers are all zero and `int_out` is low.
- R2: A 0-to-1 transition on `irq_in[i]`, seen between two rising clock edges, sets pending bit i at the second edge. Pending bit i stays set until it is acknowledged. A line that is held high after its acknowledge does not set pending bit i again.
- R3: Line 0 has the highest priority and line N-1 the lowest. When `int_out` is high, `win_id` is the lowest-numbered eligible line.
- R4: A line whose mask bit is 1 is never eligible. Its pending bit is kept, and the line becomes eligible again once the mask bit is written back to 0 (`mask_we` loads `mask_wdata` at the clock edge).
- R5: With `sfn_mode`=0, a pending line is blocked when its own in-service bit, or any in-service bit of higher priority, is set. A lower-priority in-service bit does not block it.
- R6: With `sfn_mode`=1, a line's own in-service bit does not block it. Higher-priority in-service bits still block it.
- R7: When `ack` is high and `int_out` is high at a clock edge, in-service bit `win_id` is set and pending bit `win_id` is cleared at that edge. When `ack` is high and `int_out` is low, nothing changes.
- R8: When `eoi` is high at a clock edge, the lowest-numbered set in-service bit is cleared and no other bit changes. When the in-service register is empty, `eoi` has no effect.
- R9: `int_out` is high exactly when at least one line is eligible.
- R10: `isr_out` always shows the current in-service register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_SRC | Interrupt request lines, captured on their rising edges |
| mask_we | input | 1 | Loads the mask register from `mask_wdata` |
| mask_wdata | input | N_SRC | New mask value; a 1 disables that line |
| sfn_mode | input | 1 | 0 selects plain nesting, 1 selects special nesting |
| ack | input | 1 | Acknowledge pulse from the processor |
| eoi | input | 1 | Non-specific end-of-interrupt command |
| int_out | output | 1 | Interrupt request to the processor |
| win_id | output | ID_W | Index of the winning line; valid while `int_out` is high |
| isr_out | output | N_SRC | In-service register |

## Verification
The assertions assume that `ack` and `eoi` are single-cycle strobes sampled at the rising edge. They also assume that `irq_in` is synchronous to `clk`. The count check on end-of-interrupt additionally assumes that no acknowledge arrives in the same cycle.

The stimulus changes every input only between clock edges and holds `irq_in` low throughout reset. It applies `ack` and `eoi` together only in the pseudo-random phase, where those assertions are written to tolerate the overlap. A cycle-by-cycle arithmetic model in the bench tracks the pending, in-service and mask registers through both nesting modes.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

   typedef enum logic {
      NEST_PLAIN   = 1'b0,
      NEST_SPECIAL = 1'b1
   } nest_mode_e;

   function automatic int id_width(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
   parameter int N_SRC = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] irq_in,
   input  logic [N_SRC-1:0] clr_vec,
   output logic [N_SRC-1:0] pend_q
);

   logic [N_SRC-1:0] prev_q;
   logic [N_SRC-1:0] rise;

   assign rise = irq_in & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         pend_q <= '0;
      end else begin
         prev_q <= irq_in;
         pend_q <= (pend_q & ~clr_vec) | rise;
      end
   end

   AST_CLR_TAKES : assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_vec & pend_q & ~rise)) |=> ((pend_q & $past(clr_vec & ~rise)) == '0)); // R7

endmodule

// File: rtl/irq_first_pick.sv
module irq_first_pick #(
   parameter int N_SRC = 8,
   parameter int ID_W  = 3
) (
   input  logic [N_SRC-1:0] vec,
   output logic             any,
   output logic [ID_W-1:0]  idx,
   output logic [N_SRC-1:0] onehot
);

   always_comb begin
      idx    = '0;
      onehot = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (vec[i]) begin
            idx    = ID_W'(i);
            onehot = '0;
            onehot[i] = 1'b1;
         end
      end
   end

   assign any = |vec;

   always_comb begin
      AST_PICK_ONEHOT : assert ($onehot0(onehot) && (any == (|onehot))); // R3
   end

endmodule

// File: rtl/irq_block_gen.sv
module irq_block_gen #(
   parameter int N_SRC  = 8,
   parameter bit SFN_EN = 1'b1
) (
   input  logic [N_SRC-1:0] isr,
   input  logic             sfn_mode,
   output logic [N_SRC-1:0] blocked
);

   logic [N_SRC:0] above;

   assign above[0] = 1'b0;

   for (genvar g = 0; g < N_SRC; g++) begin : g_prefix
      assign above[g+1] = above[g] | isr[g];
   end

   if (SFN_EN) begin : g_sfn
      for (genvar g = 0; g < N_SRC; g++) begin : g_bit
         assign blocked[g] = above[g] | (isr[g] & ~sfn_mode);
      end
   end else begin : g_plain
      logic unused_sfn;
      assign unused_sfn = sfn_mode;
      assign blocked = above[N_SRC:1];
   end

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
   import irq_nest_pkg::*;
#(
   parameter int N_SRC  = 8,
   parameter bit SFN_EN = 1'b1,
   localparam int ID_W  = irq_nest_pkg::id_width(N_SRC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] irq_in,
   input  logic             mask_we,
   input  logic [N_SRC-1:0] mask_wdata,
   input  logic             sfn_mode,
   input  logic             ack,
   input  logic             eoi,
   output logic             int_out,
   output logic [ID_W-1:0]  win_id,
   output logic [N_SRC-1:0] isr_out
);

   initial begin : elab_checks
      AST_PARAM_RANGE : assert (N_SRC >= 2 && N_SRC <= 64); // R3
   end

   nest_mode_e mode;
   assign mode = nest_mode_e'(sfn_mode);

   logic [N_SRC-1:0] pend_q;
   logic [N_SRC-1:0] mask_q;
   logic [N_SRC-1:0] isr_q;
   logic [N_SRC-1:0] blocked;
   logic [N_SRC-1:0] eligible;
   logic [N_SRC-1:0] win_oh;
   logic [N_SRC-1:0] eoi_oh;
   logic [ID_W-1:0]  eoi_idx;
   logic             eoi_any;
   logic             take;
   logic [N_SRC-1:0] ack_set;
   logic [N_SRC-1:0] eoi_clr;

   assign take    = ack & int_out;
   assign ack_set = take ? win_oh : '0;
   assign eoi_clr = eoi  ? eoi_oh : '0;

   irq_edge_latch #(.N_SRC(N_SRC)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq_in  (irq_in),
      .clr_vec (ack_set),
      .pend_q  (pend_q)
   );

   irq_block_gen #(.N_SRC(N_SRC), .SFN_EN(SFN_EN)) u_block (
      .isr      (isr_q),
      .sfn_mode (mode == NEST_SPECIAL),
      .blocked  (blocked)
   );

   assign eligible = pend_q & ~mask_q & ~blocked;

   irq_first_pick #(.N_SRC(N_SRC), .ID_W(ID_W)) u_win (
      .vec    (eligible),
      .any    (int_out),
      .idx    (win_id),
      .onehot (win_oh)
   );

   irq_first_pick #(.N_SRC(N_SRC), .ID_W(ID_W)) u_eoi (
      .vec    (isr_q),
      .any    (eoi_any),
      .idx    (eoi_idx),
      .onehot (eoi_oh)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         isr_q  <= '0;
      end else begin
         if (mask_we) mask_q <= mask_wdata;
         isr_q <= (isr_q & ~eoi_clr) | ack_set;
      end
   end

   assign isr_out = isr_q;

   AST_WIN_PENDING : assert property (@(posedge clk) disable iff (!rst_n)
      int_out |-> (pend_q[win_id] && !mask_q[win_id])); // R4
   AST_PLAIN_BLOCK : assert property (@(posedge clk) disable iff (!rst_n)
      (int_out && !sfn_mode) |-> !isr_q[win_id]); // R5
   AST_HIGHER_BLOCK : assert property (@(posedge clk) disable iff (!rst_n)
      int_out |-> ((isr_q & ((N_SRC'(1) << win_id) - N_SRC'(1))) == '0)); // R6
   AST_ACK_SETS : assert property (@(posedge clk) disable iff (!rst_n)
      (ack && int_out && !eoi) |=> isr_out[$past(win_id)]); // R7
   AST_ACK_IDLE : assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !int_out && !eoi) |=> $stable(isr_out)); // R7
   AST_EOI_ONE : assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !ack && eoi_any) |=> ($countones(isr_out) == $past($countones(isr_q)) - 1)); // R8
   AST_EOI_TOP : assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !ack && eoi_any) |=> !isr_out[$past(eoi_idx)]); // R8
   AST_ISR_HOLD : assert property (@(posedge clk) disable iff (!rst_n)
      (!ack && !eoi) |=> $stable(isr_out)); // R10

endmodule

// File: tb/irq_nest_ctrl_test.sv
module irq_nest_ctrl_test;

   localparam int N = 8;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] irq, mdata;
   logic       mwe, sfn, ack, eoi;
   logic       int_out;
   logic [2:0] win_id;
   logic [7:0] isr_out;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [7:0] m_req, m_isr, m_mask, m_prev;

   always #10 clk = ~clk;

   irq_nest_ctrl #(.N_SRC(N), .SFN_EN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq), .mask_we(mwe), .mask_wdata(mdata),
      .sfn_mode(sfn), .ack(ack), .eoi(eoi), .int_out(int_out),
      .win_id(win_id), .isr_out(isr_out)
   );

   task automatic chk(input int act, input int exp, input string tag);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int first_one(input logic [7:0] v);
      for (int i = 0; i < N; i++) if (v[i]) return i;
      return -1;
   endfunction

   // one clock: compare against the model at the negedge, then advance the model
   task automatic cyc();
      logic [7:0] el;
      logic [7:0] aset, eclr;
      int w, e;
      @(negedge clk);
      #1;
      for (int i = 0; i < N; i++) begin
         logic hi;
         hi = 1'b0;
         for (int j = 0; j < i; j++) hi = hi | m_isr[j];
         el[i] = m_req[i] & ~m_mask[i] & ~hi & ~(m_isr[i] & ~sfn);
      end
      w = first_one(el);
      chk(int'(int_out), int'(w >= 0), "R9 int_out");
      if (w >= 0) chk(int'(win_id), w, "R3 win_id");
      chk(int'(isr_out), int'(m_isr), "R10 isr_out");
      aset = '0;
      eclr = '0;
      if (ack && w >= 0) aset[w] = 1'b1;
      e = first_one(m_isr);
      if (eoi && e >= 0) eclr[e] = 1'b1;
      m_isr = (m_isr & ~eclr) | aset;
      m_req = (m_req & ~aset) | (irq & ~m_prev);
      if (mwe) m_mask = mdata;
      m_prev = irq;
      @(posedge clk);
      #1;
   endtask

   task automatic pulse_ack();
      ack = 1'b1; cyc(); ack = 1'b0;
   endtask

   task automatic pulse_eoi();
      eoi = 1'b1; cyc(); eoi = 1'b0;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int unsigned x;
      rst_n = 1'b0;
      irq = '0; mdata = '0; mwe = 1'b0; sfn = 1'b0; ack = 1'b0; eoi = 1'b0;
      m_req = '0; m_isr = '0; m_mask = '0; m_prev = '0;
      repeat (3) @(posedge clk);
      #1;
      chk(int'(int_out), 0, "R1 int_out after reset");
      chk(int'(isr_out), 0, "R1 isr after reset");
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;

      // plain nesting
      irq = 8'h08; cyc();
      chk(int'(int_out), 1, "R2 edge captured");
      chk(int'(win_id), 3, "R2 line 3 wins");
      irq = 8'h0A; cyc();
      chk(int'(win_id), 1, "R3 line 1 outranks 3");
      pulse_ack();
      chk(int'(isr_out), 8'h02, "R7 ack sets in-service 1");
      chk(int'(int_out), 0, "R5 higher in-service blocks 3");
      irq = 8'h08; cyc();
      irq = 8'h0A; cyc();
      chk(int'(int_out), 0, "R5 own in-service blocks in plain mode");

      // special nesting
      sfn = 1'b1; cyc();
      chk(int'(int_out), 1, "R6 own in-service passes");
      chk(int'(win_id), 1, "R6 line 1 again");
      pulse_ack();
      chk(int'(isr_out), 8'h02, "R7 in-service stays 1");
      chk(int'(int_out), 0, "R6 higher in-service still blocks 3");
      pulse_eoi();
      chk(int'(isr_out), 8'h00, "R8 eoi clears line 1");
      chk(int'(win_id), 3, "R8 line 3 now wins");
      pulse_eoi();
      chk(int'(isr_out), 8'h00, "R8 eoi on empty has no effect");

      // mask
      mwe = 1'b1; mdata = 8'h08; cyc(); mwe = 1'b0;
      chk(int'(int_out), 0, "R4 masked line blocked");
      cyc();
      mwe = 1'b1; mdata = 8'h00; cyc(); mwe = 1'b0;
      chk(int'(int_out), 1, "R4 pending kept through mask");
      chk(int'(win_id), 3, "R4 line 3 after unmask");
      pulse_ack();
      pulse_eoi();
      chk(int'(int_out), 0, "R2 held level does not re-latch");

      // higher in-service blocks in special mode; ack with no interrupt ignored
      irq = 8'h09; cyc();
      pulse_ack();
      chk(int'(isr_out), 8'h01, "R7 line 0 in service");
      pulse_ack();
      chk(int'(isr_out), 8'h01, "R7 ack with int low ignored");
      irq = 8'h29; cyc();
      chk(int'(int_out), 0, "R6 line 5 blocked by line 0");
      pulse_eoi();
      chk(int'(win_id), 5, "R8 line 5 after eoi");
      pulse_ack();
      pulse_eoi();
      irq = '0; cyc();

      // pseudo-random sweep against the model
      x = 32'h1234_5678;
      for (int c = 0; c < 4000; c++) begin
         x ^= x << 13; x ^= x >> 17; x ^= x << 5;
         for (int b = 0; b < N; b++) if (x[4*b +: 4] == 4'd0) irq[b] = ~irq[b];
         ack   = (x[2:0] == 3'd5);
         eoi   = (x[9:7] == 3'd2);
         mwe   = (x[15:11] == 5'd0);
         mdata = x[23:16] & x[31:24];
         sfn   = (c >= 2000);
         cyc();
      end
      ack = 1'b0; eoi = 1'b0; mwe = 1'b0;
      cyc();

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule